// File: doc/BRIEF.md
# DMA Request Conditioning Unit

This block sits in front of a four-channel DMA controller and shapes the request line of each channel before the controller sees it. Two channels carry expansion-slot requests and are only re-registered. One channel carries the floppy-disk controller's request and holds back its rising edge for a fixed number of clock cycles. This gives the controller time to become ready between raising its request and being read. Its falling edge is not delayed.

The remaining channel produces DRAM refresh requests. A periodic timer tick, nominally every 13 µs, raises the request on its rising edge. The request stays up until the DMA controller acknowledges it, which the controller does by performing one refresh read of DRAM. A tick that arrives while a refresh is still outstanding is absorbed, so at most one refresh request is ever pending. All four outputs are registered in the 4 MHz clock domain, and an asynchronous active-low reset clears them.

Top module: `dma_req_cond`

## Requirements
- R1: While reset is asserted and after it is released with all inputs low, all four bits of `dmaReq` are 0.
- R2: `dmaReq[0]` equals `slotReqA` and `dmaReq[3]` equals `slotReqB`, each as sampled at the previous clock edge.
- R3: `dmaReq[1]` goes to 1 after the 5th consecutive clock edge at which `floppyReq` is sampled high (parameter `DELAY`, default 5), and stays 1 while `floppyReq` stays high.
- R4: A high pulse on `floppyReq` that is sampled at fewer than `DELAY` consecutive edges never raises `dmaReq[1]`.
- R5: `dmaReq[1]` is 0 after the first clock edge at which `floppyReq` is sampled low.
- R6: `dmaReq[2]` is 1 after the first clock edge at which `refreshTick` is sampled high, provided it was sampled low at the edge before.
- R7: Once set, `dmaReq[2]` stays 1 until an edge at which `refreshAck` is sampled high, and is 0 after that edge.
- R8: A tick edge while `dmaReq[2]` is already 1 is absorbed (a single acknowledge clears it), and a tick held high for many cycles raises only one request.
- R9: When `refreshAck` and a new tick rising edge are sampled at the same edge, `dmaReq[2]` is 1 after that edge.
- R10: With a tick every 52 cycles (13 µs at 4 MHz) and each request acknowledged, consecutive rises of `dmaReq[2]` are exactly 52 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz DMA clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotReqA | input | 1 | Expansion-slot request (hard disk slot), channel 0 |
| floppyReq | input | 1 | Raw floppy-controller request, channel 1 |
| slotReqB | input | 1 | Expansion-slot request (second disk slot), channel 3 |
| refreshTick | input | 1 | Periodic timer tick for DRAM refresh |
| refreshAck | input | 1 | DMA acknowledge of the refresh channel |
| dmaReq | output | 4 | Conditioned requests to the DMA controller, bit n = channel n |

## Verification
The hardest state to reach is the refresh channel at the moment an acknowledge and a fresh tick edge land on the same clock edge. Reaching it needs a request that is already pending, a tick that has returned low, and then a tick rise timed into the acknowledge cycle. The bench builds this by raising a request, dropping the tick, and then driving tick and acknowledge together on one falling edge. A second hard case is a floppy pulse that ends exactly one cycle short of the delay. The bench reaches it by counting the edges it drives and releasing the request after four.

// File: rtl/dma_cond_pkg.sv
package dma_cond_pkg;

  // Strobes from control to datapath, valid for one clock edge
  typedef struct packed {
    logic floppyCount;   // advance the floppy hold-off counter
    logic floppyFire;    // hold-off complete: present floppy request
    logic floppyDrop;    // raw floppy request low: clear counter and output
    logic refreshSet;    // tick rising edge seen: raise refresh request
    logic refreshClear;  // acknowledge without new tick: drop refresh request
  } ctrl_strobe_t;

  function automatic int cntWidth(input int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/dma_cond_ctrl.sv
module dma_cond_ctrl
  import dma_cond_pkg::*;
#(
  parameter int DELAY = 5,
  localparam int CNT_W = cntWidth(DELAY)
)(
  input  logic             floppyReq,
  input  logic [CNT_W-1:0] floppyCnt,
  input  logic             refreshTick,
  input  logic             tickPrev,
  input  logic             refreshAck,
  output ctrl_strobe_t     strobe
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

  logic tickRise;

  always_comb begin
    tickRise            = refreshTick && !tickPrev;
    strobe              = '0;
    strobe.floppyDrop   = !floppyReq;
    strobe.floppyFire   = floppyReq && (floppyCnt == LAST);
    strobe.floppyCount  = floppyReq && (floppyCnt != LAST);
    strobe.refreshSet   = tickRise;
    strobe.refreshClear = refreshAck && !tickRise;
  end

endmodule

// File: rtl/dma_cond_datapath.sv
module dma_cond_datapath
  import dma_cond_pkg::*;
#(
  parameter int DELAY = 5,
  localparam int CNT_W = cntWidth(DELAY)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             slotReqA,
  input  logic             slotReqB,
  input  logic             refreshTick,
  input  ctrl_strobe_t     strobe,
  output logic [CNT_W-1:0] floppyCnt,
  output logic             tickPrev,
  output logic [3:0]       dmaReq
);

  logic slotQA, slotQB, floppyOut, refreshOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQA <= 1'b0;
      slotQB <= 1'b0;
    end else begin
      slotQA <= slotReqA;
      slotQB <= slotReqB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      floppyCnt <= '0;
      floppyOut <= 1'b0;
    end else if (strobe.floppyDrop) begin
      floppyCnt <= '0;
      floppyOut <= 1'b0;
    end else if (strobe.floppyFire) begin
      floppyOut <= 1'b1;
    end else if (strobe.floppyCount) begin
      floppyCnt <= floppyCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickPrev   <= 1'b0;
      refreshOut <= 1'b0;
    end else begin
      tickPrev <= refreshTick;
      if (strobe.refreshSet)        refreshOut <= 1'b1;
      else if (strobe.refreshClear) refreshOut <= 1'b0;
    end
  end

  assign dmaReq = {slotQB, refreshOut, floppyOut, slotQA};

endmodule

// File: rtl/dma_req_cond.sv
module dma_req_cond
  import dma_cond_pkg::*;
#(
  parameter int DELAY = 5
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotReqA,
  input  logic       floppyReq,
  input  logic       slotReqB,
  input  logic       refreshTick,
  input  logic       refreshAck,
  output logic [3:0] dmaReq
);

  localparam int CNT_W = cntWidth(DELAY);

  ctrl_strobe_t     strobe;
  logic [CNT_W-1:0] floppyCnt;
  logic             tickPrev;

  dma_cond_ctrl #(.DELAY(DELAY)) ctrl_i (
    .floppyReq  (floppyReq),
    .floppyCnt  (floppyCnt),
    .refreshTick(refreshTick),
    .tickPrev   (tickPrev),
    .refreshAck (refreshAck),
    .strobe     (strobe)
  );

  dma_cond_datapath #(.DELAY(DELAY)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .slotReqA   (slotReqA),
    .slotReqB   (slotReqB),
    .refreshTick(refreshTick),
    .strobe     (strobe),
    .floppyCnt  (floppyCnt),
    .tickPrev   (tickPrev),
    .dmaReq     (dmaReq)
  );

endmodule

// File: rtl/dma_cond_checker.sv
module dma_cond_checker #(
  parameter int DELAY = 5
)(
  input logic       clk,
  input logic       rstN,
  input logic       slotReqA,
  input logic       floppyReq,
  input logic       slotReqB,
  input logic       refreshTick,
  input logic       refreshAck,
  input logic [3:0] dmaReq
);

  localparam int RUN_W = $clog2(DELAY + 1);

  logic [RUN_W-1:0] runCnt;
  logic             tickQ;

  // Consecutive high samples of the raw floppy request, saturating at DELAY
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      tickQ  <= 1'b0;
    end else begin
      tickQ <= refreshTick;
      if (!floppyReq)                   runCnt <= '0;
      else if (runCnt != RUN_W'(DELAY)) runCnt <= runCnt + 1'b1;
    end
  end

  p_slot_a_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> dmaReq[0] == $past(slotReqA));

  p_slot_b_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> dmaReq[3] == $past(slotReqB));

  p_floppy_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq[1]) |-> runCnt == RUN_W'(DELAY));

  p_floppy_early_r4: assert property (@(posedge clk) disable iff (!rstN)
    (runCnt < RUN_W'(DELAY)) |-> !dmaReq[1]);

  p_floppy_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    !floppyReq |=> !dmaReq[1]);

  p_refresh_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (refreshTick && !tickQ) |=> dmaReq[2]);

  p_refresh_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq[2] && !refreshAck) |=> dmaReq[2]);

  p_refresh_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (refreshAck && !(refreshTick && !tickQ)) |=> !dmaReq[2]);

  p_refresh_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaReq[2] && !(refreshTick && !tickQ)) |=> !dmaReq[2]);

endmodule

bind dma_req_cond dma_cond_checker #(.DELAY(DELAY)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .slotReqA   (slotReqA),
  .floppyReq  (floppyReq),
  .slotReqB   (slotReqB),
  .refreshTick(refreshTick),
  .refreshAck (refreshAck),
  .dmaReq     (dmaReq)
);

// File: tb/dma_req_cond_tb.sv
module dma_req_cond_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slotReqA = 1'b0, floppyReq = 1'b0, slotReqB = 1'b0;
  logic       refreshTick = 1'b0, refreshAck = 1'b0;
  logic [3:0] dmaReq;

  int testsRun = 0;
  int testsFailed = 0;
  int cycle = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz
  always @(posedge clk) cycle <= cycle + 1;

  dma_req_cond dut_i (
    .clk(clk), .rstN(rstN), .slotReqA(slotReqA), .floppyReq(floppyReq),
    .slotReqB(slotReqB), .refreshTick(refreshTick), .refreshAck(refreshAck),
    .dmaReq(dmaReq)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cycle);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic t_reset();
    step();
    check("R1 during reset", dmaReq, 4'b0000);
    rstN = 1'b1;
    step(); step();
    check("R1 after release", dmaReq, 4'b0000);
  endtask

  task automatic t_slots();
    slotReqA = 1'b1; step();
    check("R2 slot A follows", dmaReq, 4'b0001);
    slotReqB = 1'b1; slotReqA = 1'b0; step();
    check("R2 slot B follows", dmaReq, 4'b1000);
    slotReqB = 1'b0; step();
    check("R2 both low", dmaReq, 4'b0000);
  endtask

  task automatic t_floppy_delay();
    floppyReq = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      step();
      check($sformatf("R3 edge %0d", i), {3'b0, dmaReq[1]}, (i == 5) ? 4'b0001 : 4'b0000);
    end
    step(); step();
    check("R3 stays high", {3'b0, dmaReq[1]}, 4'b0001);
    floppyReq = 1'b0; step();
    check("R5 immediate fall", {3'b0, dmaReq[1]}, 4'b0000);
  endtask

  task automatic t_floppy_short();
    floppyReq = 1'b1;
    for (int i = 0; i < 4; i++) step();
    floppyReq = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (i == 0 || i == 5) check("R4 short pulse ignored", {3'b0, dmaReq[1]}, 4'b0000);
    end
    // restart counting after a short pulse: needs a full 5 again
    floppyReq = 1'b1;
    for (int i = 0; i < 4; i++) step();
    check("R4 restart not early", {3'b0, dmaReq[1]}, 4'b0000);
    step();
    check("R3 restart full delay", {3'b0, dmaReq[1]}, 4'b0001);
    floppyReq = 1'b0; step();
  endtask

  task automatic t_refresh_basic();
    refreshTick = 1'b1; step();
    check("R6 set on tick edge", {3'b0, dmaReq[2]}, 4'b0001);
    refreshTick = 1'b0;
    for (int i = 0; i < 8; i++) step();
    check("R7 held until ack", {3'b0, dmaReq[2]}, 4'b0001);
    refreshAck = 1'b1; step(); refreshAck = 1'b0;
    check("R7 cleared by ack", {3'b0, dmaReq[2]}, 4'b0000);
  endtask

  task automatic t_refresh_absorb();
    refreshTick = 1'b1; step(); refreshTick = 1'b0; step(); step();
    refreshTick = 1'b1; step(); refreshTick = 1'b0; step();
    check("R8 pending stays", {3'b0, dmaReq[2]}, 4'b0001);
    refreshAck = 1'b1; step(); refreshAck = 1'b0;
    for (int i = 0; i < 10; i++) step();
    check("R8 second tick not queued", {3'b0, dmaReq[2]}, 4'b0000);
    // tick held high across an acknowledge
    refreshTick = 1'b1; step(); step(); step();
    refreshAck = 1'b1; step(); refreshAck = 1'b0;
    for (int i = 0; i < 6; i++) step();
    check("R8 level tick no retrigger", {3'b0, dmaReq[2]}, 4'b0000);
    refreshTick = 1'b0; step();
  endtask

  task automatic t_refresh_collide();
    refreshTick = 1'b1; step(); refreshTick = 1'b0; step();
    refreshTick = 1'b1; refreshAck = 1'b1; step();
    refreshTick = 1'b0; refreshAck = 1'b0;
    check("R9 ack with new tick keeps set", {3'b0, dmaReq[2]}, 4'b0001);
    refreshAck = 1'b1; step(); refreshAck = 1'b0;
    check("R9 later ack clears", {3'b0, dmaReq[2]}, 4'b0000);
  endtask

  task automatic t_refresh_spacing();
    int riseAt[4];
    int n = 0;
    logic prev = 1'b0;
    for (int c = 0; c < 4 * 52 + 10; c++) begin
      refreshTick = ((c % 52) == 0);
      refreshAck  = ((c % 52) == 3);
      step();
      if (dmaReq[2] && !prev && n < 4) begin riseAt[n] = c; n++; end
      prev = dmaReq[2];
    end
    refreshTick = 1'b0; refreshAck = 1'b0;
    check("R10 four requests seen", 4'(n), 4'd4);
    for (int k = 1; k < 4; k++)
      if (k < n) check($sformatf("R10 spacing %0d", k), 4'(riseAt[k] - riseAt[k-1] - 48), 4'd4);
  endtask

  initial begin
    t_reset();
    t_slots();
    t_floppy_delay();
    t_floppy_short();
    t_refresh_basic();
    t_refresh_absorb();
    t_refresh_collide();
    t_refresh_spacing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        testsRun++; testsFailed++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule